// File: doc/BRIEF.md
# Control-OUT Packet Receive Buffer

This block stores a single data packet arriving on the OUT direction of a control endpoint. Setup packets never reach it. The serial-side deserializer presents bytes one per cycle and then marks the end of the packet as good or bad. A good end records how many bytes arrived in a size register and raises a receive-complete flag. The buffer then locks so firmware can take its time.

Firmware reads the packet through a read-only byte port. The port shows the byte at an internal read pointer, and each read strobe advances that pointer by one. When firmware has finished, it pulses a read-finished trigger. This reopens the buffer for the next packet. A separate clear strobe returns the whole block to its initial state.

The `rx_ready` output tells the protocol side whether a packet can be taken. When it is low, the protocol side answers with a NAK. Token decoding and CRC checking happen upstream. The contents of the storage after reset are undefined.

Top module: `ctrl_out_rx_buf`

## Requirements
- R1: After reset or a `clr` pulse, `rx_ready` is 1, `rx_cmpl` is 0, `rx_size` is 0 and the read pointer is at byte 0.
- R2: While `rx_ready` is 1, bytes strobed by `wr_valid` are stored at positions 0, 1, 2 … in arrival order. A good end (`end_ok`) with at most 8 bytes copies the byte count into `rx_size`, sets `rx_cmpl` and drops `rx_ready` on the next cycle.
- R3: While `rx_ready` is 0, `wr_valid`, `end_ok` and `end_bad` are ignored. Stored bytes and `rx_size` stay unchanged.
- R4: `rd_data` shows the stored byte at the read pointer. Each `rd_strobe` while the buffer is held advances the pointer by one, and it wraps from position 7 back to position 0.
- R5: A `rd_done` pulse while the buffer is held clears `rx_cmpl`, raises `rx_ready` and returns the read pointer to 0. `rx_size` keeps its value until the next good end.
- R6: A bad end (`end_bad`, which wins over a simultaneous `end_ok`) discards the partial bytes. It leaves `rx_size`, `rx_cmpl` and `rx_ready` as they were, and the next packet starts again at position 0.
- R7: A packet of more than 8 bytes that ends with `end_ok` is discarded exactly like a bad end.
- R8: A byte strobed in the same cycle as an end strobe is not stored and not counted.
- R9: `clr` takes precedence over `rd_done`, `rd_strobe` and any write or end strobe in the same cycle.
- R10: A good end with zero bytes is a valid packet. `rx_size` becomes 0, `rx_cmpl` is set and the buffer locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Incoming byte strobe from the deserializer |
| wr_data | input | 8 | Incoming byte |
| end_ok | input | 1 | Packet ended without error |
| end_bad | input | 1 | Packet ended with an error |
| rx_ready | output | 1 | Buffer can accept a packet (low means NAK) |
| rd_strobe | input | 1 | Firmware read strobe, advances the read pointer |
| rd_data | output | 8 | Byte at the read pointer |
| rd_done | input | 1 | Firmware read-finished trigger |
| clr | input | 1 | Reinitialise the buffer |
| rx_size | output | 4 | Byte count of the last good packet |
| rx_cmpl | output | 1 | Receive-complete flag |

## Verification
A wrong write count shows up in `rx_size` one cycle after the good end. A stray write into a held buffer shows up at `rd_data` as soon as firmware steps over the corrupted position. A lock state that disagrees with the flag appears at once as `rx_ready` and `rx_cmpl` both high, or both low, while a packet is held. A read pointer that is not reset on `rd_done` or `clr` only becomes visible on the next packet's first read, so the sweep reads every packet from its first byte after each rearm.

// File: rtl/ctrl_out_rx_pkg.sv
package ctrl_out_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        BUF_OPEN = 1'b0,
        BUF_HELD = 1'b1
    } buf_state_e;

    typedef struct packed {
        logic good;
        logic bad;
    } pkt_end_t;

    // Width of a counter able to hold the values 0..depth inclusive.
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

    // Read pointer step with wrap at the last position.
    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/ctrl_out_rx_mem.sv
module ctrl_out_rx_mem #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == PW'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ctrl_out_rx_ctl.sv
module ctrl_out_rx_ctl
    import ctrl_out_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_valid,
    input  pkt_end_t      pend,
    input  logic          rd_strobe,
    input  logic          rd_done,
    output logic          we,
    output logic [PW-1:0] waddr,
    output logic [PW-1:0] raddr,
    output logic [CW-1:0] size,
    output logic          cmpl,
    output logic          ready
);

    buf_state_e    state_q;
    logic [CW-1:0] wcnt_q;
    logic          ovf_q;
    logic [PW-1:0] rptr_q;
    logic [CW-1:0] size_q;
    logic          cmpl_q;
    logic          any_end;
    logic          room;

    assign any_end = pend.good | pend.bad;
    assign room    = (wcnt_q < CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= BUF_OPEN;
            wcnt_q  <= '0;
            ovf_q   <= 1'b0;
            rptr_q  <= '0;
            size_q  <= '0;
            cmpl_q  <= 1'b0;
        end else if (state_q == BUF_OPEN) begin
            if (pend.bad) begin
                wcnt_q <= '0;
                ovf_q  <= 1'b0;
            end else if (pend.good) begin
                if (!ovf_q) begin
                    size_q  <= wcnt_q;
                    cmpl_q  <= 1'b1;
                    state_q <= BUF_HELD;
                    rptr_q  <= '0;
                end
                wcnt_q <= '0;
                ovf_q  <= 1'b0;
            end else if (wr_valid) begin
                if (room) begin
                    wcnt_q <= wcnt_q + 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
        end else begin
            if (rd_done) begin
                state_q <= BUF_OPEN;
                cmpl_q  <= 1'b0;
                rptr_q  <= '0;
            end else if (rd_strobe) begin
                rptr_q <= PW'(wrap_inc(32'(rptr_q), DEPTH));
            end
        end
    end

    assign we    = (state_q == BUF_OPEN) && wr_valid && !any_end && room && !clr && !rst;
    assign waddr = wcnt_q[PW-1:0];
    assign raddr = rptr_q;
    assign size  = size_q;
    assign cmpl  = cmpl_q;
    assign ready = (state_q == BUF_OPEN);

endmodule

// File: rtl/ctrl_out_rx_buf.sv
module ctrl_out_rx_buf
    import ctrl_out_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              end_ok,
    input  logic              end_bad,
    output logic              rx_ready,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              rd_done,
    input  logic              clr,
    output logic [CW-1:0]     rx_size,
    output logic              rx_cmpl
);

    pkt_end_t      pend;
    logic          we;
    logic [PW-1:0] waddr;
    logic [PW-1:0] raddr;

    assign pend.good = end_ok;
    assign pend.bad  = end_bad;

    ctrl_out_rx_ctl #(.DEPTH(DEPTH)) ctl_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_valid (wr_valid),
        .pend     (pend),
        .rd_strobe(rd_strobe),
        .rd_done  (rd_done),
        .we       (we),
        .waddr    (waddr),
        .raddr    (raddr),
        .size     (rx_size),
        .cmpl     (rx_cmpl),
        .ready    (rx_ready)
    );

    ctrl_out_rx_mem #(.DEPTH(DEPTH), .DW(BYTE_W)) mem_i (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wr_data),
        .raddr(raddr),
        .rdata(rd_data)
    );

endmodule

// File: rtl/ctrl_out_rx_buf_chk.sv
module ctrl_out_rx_buf_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          end_ok,
    input logic          end_bad,
    input logic          rx_ready,
    input logic          rd_strobe,
    input logic          rd_done,
    input logic          clr,
    input logic [CW-1:0] rx_size,
    input logic          rx_cmpl
);

    // R1: clear returns to the open, empty state
    assert_clear_state_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rx_ready && !rx_cmpl && rx_size == '0));

    // R2: a good end into an open buffer locks it with the flag set
    assert_good_end_locks_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && end_ok && !end_bad && !clr && !rx_cmpl && rx_size <= CW'(DEPTH)) |=>
        (rx_cmpl || rx_ready));

    // R3: a held buffer keeps its size and stays locked until rearmed
    assert_held_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !clr && !rd_done) |=> ($stable(rx_size) && !rx_ready && rx_cmpl));

    // R3: flag and ready never agree
    assert_flag_vs_ready_R3: assert property (@(posedge clk) disable iff (rst)
        rx_cmpl != rx_ready);

    // R5: read-finished reopens a held buffer
    assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && rd_done && !clr) |=> (rx_ready && !rx_cmpl && $stable(rx_size)));

    // R6: a bad end leaves size and flag as they were
    assert_bad_end_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && end_bad && !clr) |=> ($stable(rx_size) && rx_ready && !rx_cmpl));

    // R2: the count never exceeds the storage depth
    assert_size_bound_R2: assert property (@(posedge clk) disable iff (rst)
        rx_size <= CW'(DEPTH));

endmodule

bind ctrl_out_rx_buf ctrl_out_rx_buf_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .end_ok   (end_ok),
    .end_bad  (end_bad),
    .rx_ready (rx_ready),
    .rd_strobe(rd_strobe),
    .rd_done  (rd_done),
    .clr      (clr),
    .rx_size  (rx_size),
    .rx_cmpl  (rx_cmpl)
);

// File: tb/ctrl_out_rx_buf_tb.sv
module ctrl_out_rx_buf_tb_top;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       end_ok = 1'b0;
    logic       end_bad = 1'b0;
    logic       rx_ready;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rd_done = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] rx_size;
    logic       rx_cmpl;

    int checks = 0;
    int errors = 0;
    int exp_size = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ctrl_out_rx_buf dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .end_ok(end_ok), .end_bad(end_bad), .rx_ready(rx_ready),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_done(rd_done),
        .clr(clr), .rx_size(rx_size), .rx_cmpl(rx_cmpl)
    );

    function automatic logic [7:0] pat(input int seed, input int idx);
        return 8'((seed * 37 + idx * 11 + 5) & 8'hFF);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_status(input string req, input int rdy, input int flag, input int size);
        chk({req, " rx_ready"}, int'(rx_ready), rdy);
        chk({req, " rx_cmpl"}, int'(rx_cmpl), flag);
        chk({req, " rx_size"}, int'(rx_size), size);
    endtask

    // Sends len bytes, then an end. mode 0 = good, 1 = bad, 2 = both strobes.
    task automatic send(input int seed, input int len, input int mode);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_data  = pat(seed, i);
            tick();
        end
        wr_valid = 1'b0;
        end_ok   = (mode != 1);
        end_bad  = (mode != 0);
        tick();
        end_ok  = 1'b0;
        end_bad = 1'b0;
    endtask

    // Reads len bytes from position 0 and compares against the pattern.
    task automatic read_back(input string req, input int seed, input int len);
        for (int i = 0; i < len; i++) begin
            chk(req, int'(rd_data), int'(pat(seed, i)));
            rd_strobe = 1'b1;
            tick();
            rd_strobe = 1'b0;
        end
    endtask

    task automatic rearm();
        rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk_status("R1 reset", 1, 0, 0);

        // R2, R4, R5, R10: sweep all legal lengths
        for (int len = 0; len <= DEPTH; len++) begin
            send(len, len, 0);
            exp_size = len;
            chk_status(len == 0 ? "R10 zero length" : "R2 good end", 0, 1, exp_size);
            read_back("R4 read data", len, len);
            if (len == DEPTH) begin
                chk("R4 wrap to 0", int'(rd_data), int'(pat(len, 0)));
            end
            rearm();
            chk_status("R5 rearm", 1, 0, exp_size);
        end

        // R3: writes and ends into a held buffer are ignored
        send(20, 5, 0);
        exp_size = 5;
        send(21, 7, 0);
        chk_status("R3 held ignores good end", 0, 1, 5);
        send(22, 3, 1);
        chk_status("R3 held ignores bad end", 0, 1, 5);
        read_back("R3 data intact", 20, 5);
        rearm();
        // R5: read pointer back at 0 on the next packet
        send(23, 4, 0);
        exp_size = 4;
        read_back("R5 pointer reset", 23, 2);
        rearm();
        send(24, 3, 0);
        exp_size = 3;
        read_back("R5 pointer reset after partial read", 24, 3);
        rearm();

        // R6: bad ends at every length leave state unchanged
        for (int len = 0; len <= DEPTH; len++) begin
            send(30 + len, len, 1);
            chk_status("R6 bad end", 1, 0, exp_size);
        end
        send(40, 6, 2);
        chk_status("R6 bad wins over good", 1, 0, exp_size);
        send(41, 2, 0);
        exp_size = 2;
        chk_status("R6 next packet after bad", 0, 1, 2);
        read_back("R6 restarts at 0", 41, 2);
        rearm();

        // R7: oversize packets are discarded
        for (int len = DEPTH + 1; len <= DEPTH + 3; len++) begin
            send(50 + len, len, 0);
            chk_status("R7 oversize", 1, 0, exp_size);
        end
        send(60, 8, 0);
        exp_size = 8;
        read_back("R7 after oversize", 60, 8);
        rearm();

        // R8: byte alongside end is dropped
        send(70, 2, -1 + 1);
        rearm();
        wr_valid = 1'b1; wr_data = pat(71, 0); tick();
        wr_valid = 1'b1; wr_data = pat(71, 1); end_ok = 1'b1; tick();
        wr_valid = 1'b0; end_ok = 1'b0;
        chk_status("R8 byte with end", 0, 1, 1);
        read_back("R8 data", 71, 1);
        rearm();

        // R9: clear wins over same-cycle rd_done and writes
        send(80, 4, 0);
        clr = 1'b1; rd_done = 1'b1; rd_strobe = 1'b1; wr_valid = 1'b1; end_ok = 1'b1;
        tick();
        clr = 1'b0; rd_done = 1'b0; rd_strobe = 1'b0; wr_valid = 1'b0; end_ok = 1'b0;
        chk_status("R9 clr priority", 1, 0, 0);
        send(81, 3, 0);
        chk_status("R1 after clr", 0, 1, 3);
        read_back("R1 pointer after clr", 81, 3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule